// File: doc/BRIEF.md
# Hash Engine Command Sequence Checker

This block sits beside a sponge-based hash engine and polices the software command stream that drives it. It follows the engine through its operating phases (idle, message feed, processing, absorbed, squeezing and a terminal error phase). On every cycle it decides whether the command presented is allowed in the current phase. When a message is about to begin, it also checks that the configured mode and strength form a supported pair and, in keyed operation, that the six-byte prefix holds the expected encoded name.

Errors are reported as a one-cycle pulse carrying a 3-bit code. Where several errors occur in the same cycle, a fixed priority picks the code. A separate blocking output rises in the same cycle as a blocking error, and the phase register then keeps its value instead of advancing. An escalation input drives the block into a terminal phase that only reset can leave. The hash datapath, the entropy source and the register interface are outside the block; their handshakes arrive as plain inputs.

Top module: `hash_cmd_seq_chk`

## Requirements
- R1: After the asynchronous active-low reset, phase_o is 0 (idle), err_valid_o is 0, err_code_o is 0 and block_o is 0 with no error input active. Phase encodings: idle 0, feed 1, processing 2, absorbed 3, squeezing 4, terminal 7. Command encodings on cmd_i: nop 0, start 1, process 2, manual run 3, done 4; the values 5 to 7 are illegal in every non-terminal phase.
- R2: In idle, nop and start are legal. Start moves to feed only when app_active_i is 0; with app_active_i at 1 it leaves the phase at idle and reports nothing. Any other command is a sequence error.
- R3: In feed, nop and process are legal, and process moves to processing. Any other command is a sequence error.
- R4: In processing, any non-nop command is a sequence error. The phase moves to absorbed only when absorbed_i equals exactly 4'b1010; every other value leaves it in processing.
- R5: In absorbed, nop, manual run and done are legal. Manual run moves to squeezing and done returns to idle. Start and process are sequence errors.
- R6: In squeezing, any non-nop command is a sequence error. A high perm_done_i returns the phase to absorbed.
- R7: On the idle-to-feed step, a mode/strength error is raised unless the pair is legal. mode_i encodings are 0 for fixed-length hash, 2 for extendable output and 3 for customizable extendable output. strength_i encodings are 128→0, 224→1, 256→2, 384→3 and 512→4. The legal pairs are mode 0 with strength 224, 256, 384 or 512, and mode 2 or 3 with strength 128 or 256. The error blocks (raises block_o, holds idle) only when allow_unsupported_i is 0; otherwise the phase advances.
- R8: On the idle-to-feed step with keyed_en_i at 1, a prefix error is raised when prefix_i differs from the PREFIX_EXP parameter. A prefix error does not block.
- R9: block_o is high in the same cycle as a sequence error, an entropy_err_i input, or a blocking mode/strength error. While block_o is high and escalate_i is low, the phase holds at the next edge.
- R10: Error codes: 1 sequence, 2 mode/strength, 3 prefix, 4 entropy. When several errors coincide, the lowest of these codes is reported.
- R11: err_valid_o and err_code_o are registered. An error in cycle n shows in cycle n+1 only; a cycle without error gives err_valid_o 0 and err_code_o 0 one edge later.
- R12: escalate_i at 1 moves the phase to terminal at the next edge from any phase, even while blocked. Terminal is never left before reset, flags no command as a sequence error, and an illegal phase encoding also leads to terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Software command |
| app_active_i | input | 1 | Hardware application interface busy |
| absorbed_i | input | 4 | Multi-bit absorbed indication, true only at 4'b1010 |
| perm_done_i | input | 1 | Permutation done pulse |
| entropy_err_i | input | 1 | Entropy not ready error |
| escalate_i | input | 1 | Escalation request |
| mode_i | input | 2 | Hash mode |
| strength_i | input | 3 | Security strength |
| keyed_en_i | input | 1 | Keyed MAC operation enabled |
| prefix_i | input | 48 | Configured six-byte prefix |
| allow_unsupported_i | input | 1 | Make mode/strength errors non-blocking |
| phase_o | output | 3 | Current phase |
| block_o | output | 1 | Blocking error this cycle |
| err_valid_o | output | 1 | Error report valid pulse |
| err_code_o | output | 3 | Error code, 0 when none |

## Verification
block_o is combinational and is due in the cycle in which the offending inputs are applied. The phase and the error pulse are due one clock edge later. The bench drives inputs on the falling edge and samples block_o a quarter period later, before the rising edge. It samples phase_o, err_valid_o and err_code_o one time unit after the rising edge and compares each against a bench model stepped once per cycle. The assertions state the same one-edge relations for the hold, escalation, sequence and mode-blocking rules.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int CMD_W   = 3;
  localparam int PHASE_W = 3;
  localparam int CODE_W  = 3;
  localparam int MODE_W  = 2;
  localparam int STR_W   = 3;

  typedef enum logic [CMD_W-1:0] {
    CmdNop = 3'd0, CmdStart = 3'd1, CmdProcess = 3'd2, CmdManual = 3'd3, CmdDone = 3'd4
  } cmd_e;

  typedef enum logic [PHASE_W-1:0] {
    PhIdle = 3'd0, PhFeed = 3'd1, PhProc = 3'd2, PhAbsorbed = 3'd3,
    PhSqueeze = 3'd4, PhTerm = 3'd7
  } phase_e;

  typedef enum logic [CODE_W-1:0] {
    ErrNone = 3'd0, ErrSeq = 3'd1, ErrModeStr = 3'd2, ErrPrefix = 3'd3, ErrEntropy = 3'd4
  } err_code_e;

  typedef enum logic [MODE_W-1:0] {
    ModeHash = 2'd0, ModeRsvd = 2'd1, ModeXof = 2'd2, ModeCXof = 2'd3
  } mode_e;

  typedef enum logic [STR_W-1:0] {
    Str128 = 3'd0, Str224 = 3'd1, Str256 = 3'd2, Str384 = 3'd3, Str512 = 3'd4
  } strength_e;
endpackage

// File: rtl/hcs_phase_fsm.sv
module hcs_phase_fsm
  import hcs_pkg::*;
#(
  parameter int          ABS_W    = 4,
  parameter logic [ABS_W-1:0] ABS_TRUE = 4'b1010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic             app_active_i,
  input  logic [ABS_W-1:0] absorbed_i,
  input  logic             perm_done_i,
  input  logic             escalate_i,
  input  logic             hold_i,
  output phase_e           phase_o,
  output logic             go_o,
  output logic             seq_err_o
);
  phase_e phase_q, phase_d, phase_n;

  always_comb begin
    phase_d   = phase_q;
    seq_err_o = 1'b0;
    unique case (phase_q)
      PhIdle: begin
        seq_err_o = !(cmd_i inside {CmdNop, CmdStart});
        if (cmd_i == CmdStart && !app_active_i) phase_d = PhFeed;
      end
      PhFeed: begin
        seq_err_o = !(cmd_i inside {CmdNop, CmdProcess});
        if (cmd_i == CmdProcess) phase_d = PhProc;
      end
      PhProc: begin
        seq_err_o = (cmd_i != CmdNop);
        if (absorbed_i == ABS_TRUE) phase_d = PhAbsorbed;  // strict multi-bit test
      end
      PhAbsorbed: begin
        seq_err_o = !(cmd_i inside {CmdNop, CmdManual, CmdDone});
        if (cmd_i == CmdManual)    phase_d = PhSqueeze;
        else if (cmd_i == CmdDone) phase_d = PhIdle;
      end
      PhSqueeze: begin
        seq_err_o = (cmd_i != CmdNop);
        if (perm_done_i) phase_d = PhAbsorbed;
      end
      PhTerm:  phase_d = PhTerm;
      default: phase_d = PhTerm;
    endcase
  end

  assign go_o = (phase_q == PhIdle) && (phase_d == PhFeed);

  // escalation and terminal/illegal encodings override the hold
  always_comb begin
    if (escalate_i || phase_d == PhTerm) phase_n = PhTerm;
    else if (hold_i)                     phase_n = phase_q;
    else                                 phase_n = phase_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PhIdle;
    else         phase_q <= phase_n;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/hcs_cfg_check.sv
module hcs_cfg_check
  import hcs_pkg::*;
#(
  parameter int                  PREFIX_W   = 48,
  parameter logic [PREFIX_W-1:0] PREFIX_EXP = 48'h4341_4D4B_2001
) (
  input  logic                go_i,
  input  mode_e               mode_i,
  input  strength_e           strength_i,
  input  logic                keyed_en_i,
  input  logic [PREFIX_W-1:0] prefix_i,
  output logic                mode_err_o,
  output logic                prefix_err_o
);
  logic pair_ok;

  always_comb begin
    unique case (mode_i)
      ModeHash:         pair_ok = strength_i inside {Str224, Str256, Str384, Str512};
      ModeXof, ModeCXof: pair_ok = strength_i inside {Str128, Str256};
      default:          pair_ok = 1'b0;
    endcase
  end

  assign mode_err_o   = go_i && !pair_ok;
  assign prefix_err_o = go_i && keyed_en_i && (prefix_i != PREFIX_EXP);
endmodule

// File: rtl/hcs_err_report.sv
module hcs_err_report
  import hcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_err_i,
  input  logic              mode_err_i,
  input  logic              prefix_err_i,
  input  logic              entropy_err_i,
  output logic              err_valid_o,
  output logic [CODE_W-1:0] err_code_o
);
  err_code_e code_d;

  always_comb begin
    if (seq_err_i)          code_d = ErrSeq;
    else if (mode_err_i)    code_d = ErrModeStr;
    else if (prefix_err_i)  code_d = ErrPrefix;
    else if (entropy_err_i) code_d = ErrEntropy;
    else                    code_d = ErrNone;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_valid_o <= 1'b0;
      err_code_o  <= '0;
    end else begin
      err_valid_o <= (code_d != ErrNone);
      err_code_o  <= code_d;
    end
  end
endmodule

// File: rtl/hash_cmd_seq_chk.sv
module hash_cmd_seq_chk
  import hcs_pkg::*;
#(
  parameter int                  ABS_W      = 4,
  parameter logic [ABS_W-1:0]    ABS_TRUE   = 4'b1010,
  parameter int                  PREFIX_W   = 48,
  parameter logic [PREFIX_W-1:0] PREFIX_EXP = 48'h4341_4D4B_2001
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          cmd_i,
  input  logic                app_active_i,
  input  logic [ABS_W-1:0]    absorbed_i,
  input  logic                perm_done_i,
  input  logic                entropy_err_i,
  input  logic                escalate_i,
  input  logic [1:0]          mode_i,
  input  logic [2:0]          strength_i,
  input  logic                keyed_en_i,
  input  logic [PREFIX_W-1:0] prefix_i,
  input  logic                allow_unsupported_i,
  output logic [2:0]          phase_o,
  output logic                block_o,
  output logic                err_valid_o,
  output logic [2:0]          err_code_o
);
  phase_e phase;
  logic   go, seq_err, mode_err, prefix_err;

  assign block_o = seq_err || entropy_err_i || (mode_err && !allow_unsupported_i);

  hcs_phase_fsm #(.ABS_W(ABS_W), .ABS_TRUE(ABS_TRUE)) u_fsm (
    .clk_i, .rst_ni,
    .cmd_i        (cmd_e'(cmd_i)),
    .app_active_i,
    .absorbed_i,
    .perm_done_i,
    .escalate_i,
    .hold_i       (block_o),
    .phase_o      (phase),
    .go_o         (go),
    .seq_err_o    (seq_err)
  );

  hcs_cfg_check #(.PREFIX_W(PREFIX_W), .PREFIX_EXP(PREFIX_EXP)) u_cfg (
    .go_i         (go),
    .mode_i       (mode_e'(mode_i)),
    .strength_i   (strength_e'(strength_i)),
    .keyed_en_i,
    .prefix_i,
    .mode_err_o   (mode_err),
    .prefix_err_o (prefix_err)
  );

  hcs_err_report u_rep (
    .clk_i, .rst_ni,
    .seq_err_i     (seq_err),
    .mode_err_i    (mode_err),
    .prefix_err_i  (prefix_err),
    .entropy_err_i,
    .err_valid_o,
    .err_code_o
  );

  assign phase_o = phase;
endmodule

// File: rtl/hcs_checker.sv
module hcs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cmd_i,
  input logic       app_active_i,
  input logic       escalate_i,
  input logic [1:0] mode_i,
  input logic [2:0] strength_i,
  input logic       allow_unsupported_i,
  input logic [2:0] phase_o,
  input logic       block_o,
  input logic       err_valid_o,
  input logic [2:0] err_code_o
);
  logic pair_ok;
  assign pair_ok = (mode_i == 2'd0 && strength_i inside {3'd1, 3'd2, 3'd3, 3'd4}) ||
                   (mode_i inside {2'd2, 2'd3} && strength_i inside {3'd0, 3'd2});

  a_r12_escalate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    escalate_i |=> phase_o == 3'd7);

  a_r12_terminal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd7 |=> phase_o == 3'd7);

  a_r9_block_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_o && !escalate_i) |=> phase_o == $past(phase_o));

  a_r4_proc_cmd_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2 && cmd_i != 3'd0) |=> (err_valid_o && err_code_o == 3'd1));

  a_r7_mode_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0 && cmd_i == 3'd1 && !app_active_i && !pair_ok &&
     !allow_unsupported_i && !escalate_i) |=> (phase_o == 3'd0 && err_code_o == 3'd2));

  a_r11_valid_matches_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> err_code_o inside {3'd1, 3'd2, 3'd3, 3'd4});
endmodule

bind hash_cmd_seq_chk hcs_checker u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .cmd_i               (cmd_i),
  .app_active_i        (app_active_i),
  .escalate_i          (escalate_i),
  .mode_i              (mode_i),
  .strength_i          (strength_i),
  .allow_unsupported_i (allow_unsupported_i),
  .phase_o             (phase_o),
  .block_o             (block_o),
  .err_valid_o         (err_valid_o),
  .err_code_o          (err_code_o)
);

// File: tb/hash_cmd_seq_chk_tb.sv
module hash_cmd_seq_chk_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] PFX = 48'h4341_4D4B_2001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd;
  logic        app_active, perm_done, entropy_err, escalate, keyed_en, allow_uns;
  logic [3:0]  absorbed;
  logic [1:0]  mode;
  logic [2:0]  strength;
  logic [47:0] prefix;
  logic [2:0]  phase;
  logic        block, err_valid;
  logic [2:0]  err_code;

  int n_tot = 0, n_bad = 0;
  bit finished = 1'b0;
  int m_ph = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_cmd_seq_chk u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .app_active_i(app_active),
    .absorbed_i(absorbed), .perm_done_i(perm_done), .entropy_err_i(entropy_err),
    .escalate_i(escalate), .mode_i(mode), .strength_i(strength), .keyed_en_i(keyed_en),
    .prefix_i(prefix), .allow_unsupported_i(allow_uns), .phase_o(phase),
    .block_o(block), .err_valid_o(err_valid), .err_code_o(err_code)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit pair_legal(logic [1:0] md, logic [2:0] st);
    return (md == 2'd0 && st >= 3'd1 && st <= 3'd4) ||
           ((md == 2'd2 || md == 2'd3) && (st == 3'd0 || st == 3'd2));
  endfunction

  function automatic bit seq_bad(int ph, logic [2:0] c);
    case (ph)
      0: return !(c == 3'd0 || c == 3'd1);
      1: return !(c == 3'd0 || c == 3'd2);
      3: return !(c == 3'd0 || c == 3'd3 || c == 3'd4);
      7: return 1'b0;
      default: return c != 3'd0;
    endcase
  endfunction

  function automatic int nxt_phase(int ph);
    case (ph)
      0: return (cmd == 3'd1 && !app_active) ? 1 : 0;
      1: return (cmd == 3'd2) ? 2 : 1;
      2: return (absorbed == 4'b1010) ? 3 : 2;
      3: return (cmd == 3'd3) ? 4 : (cmd == 3'd4) ? 0 : 3;
      4: return perm_done ? 3 : 4;
      default: return 7;
    endcase
  endfunction

  function automatic string tag_of(int ph);
    case (ph)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3: return "R5"; 4: return "R6"; default: return "R12";
    endcase
  endfunction

  task automatic idle_inputs();
    cmd = 3'd0; app_active = 0; absorbed = 4'd0; perm_done = 0; entropy_err = 0;
    escalate = 0; mode = 2'd0; strength = 3'd2; keyed_en = 0; prefix = PFX; allow_uns = 0;
  endtask

  // one cycle: inputs already set after a falling edge
  task automatic cyc(string tag);
    bit s, go, ms, pf, blk;
    int nx, code, next_ph;
    s  = seq_bad(m_ph, cmd);
    nx = nxt_phase(m_ph);
    go = (m_ph == 0) && (nx == 1);
    ms = go && !pair_legal(mode, strength);
    pf = go && keyed_en && (prefix != PFX);
    blk = s || entropy_err || (ms && !allow_uns);
    code = s ? 1 : ms ? 2 : pf ? 3 : entropy_err ? 4 : 0;
    next_ph = (escalate || nx == 7) ? 7 : blk ? m_ph : nx;
    #(CLK_PERIOD/4);
    chk({tag, " R9"}, "block_o", int'(block), int'(blk));
    @(posedge clk); #1;
    m_ph = next_ph;
    chk(tag, "phase_o", int'(phase), m_ph);
    chk({tag, " R11"}, "err_valid_o", int'(err_valid), int'(code != 0));
    chk({tag, " R10"}, "err_code_o", int'(err_code), code);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle_inputs(); m_ph = 0;
    #(CLK_PERIOD/4);
    chk("R1", "phase_o", int'(phase), 0);
    chk("R1", "err_valid_o", int'(err_valid), 0);
    chk("R1", "err_code_o", int'(err_code), 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    idle_inputs();
    #(CLK_PERIOD*2);
    do_reset();
    chk("R1", "block_o", int'(block), 0);

    // R2 idle
    cmd = 3'd2; cyc("R2");
    chk("R2", "code after process in idle", int'(err_code), 1);
    cmd = 3'd1; app_active = 1; cyc("R2");
    chk("R2", "phase with app active", int'(phase), 0);
    cmd = 3'd1; cyc("R2");
    chk("R2", "phase after start", int'(phase), 1);
    // R3 feed
    cmd = 3'd4; cyc("R3");
    cmd = 3'd7; cyc("R3");
    cmd = 3'd2; entropy_err = 1; cyc("R9");
    chk("R9", "feed held on entropy error", int'(phase), 1);
    cmd = 3'd2; cyc("R3");
    // R4 processing
    absorbed = 4'b0101; cyc("R4");
    absorbed = 4'b1011; cyc("R4");
    absorbed = 4'b1010; cmd = 3'd1; cyc("R4");
    chk("R4", "blocked in processing", int'(phase), 2);
    absorbed = 4'b1010; cyc("R4");
    chk("R4", "absorbed reached", int'(phase), 3);
    // R5 absorbed, R6 squeezing
    cmd = 3'd2; cyc("R5");
    cmd = 3'd3; cyc("R5");
    perm_done = 1; cmd = 3'd3; cyc("R6");
    chk("R6", "held in squeezing", int'(phase), 4);
    cyc("R6");
    perm_done = 1; cyc("R6");
    cmd = 3'd4; cyc("R5");
    chk("R5", "done returns idle", int'(phase), 0);
    cyc("R11");
    chk("R11", "no pulse without error", int'(err_valid), 0);

    // R7 mode/strength
    cmd = 3'd1; mode = 2'd2; strength = 3'd3; cyc("R7");
    chk("R7", "blocked mode holds idle", int'(phase), 0);
    cmd = 3'd1; mode = 2'd1; strength = 3'd2; allow_uns = 1; cyc("R7");
    chk("R7", "allowed mode advances", int'(phase), 1);
    do_reset();
    cmd = 3'd1; mode = 2'd0; strength = 3'd0; cyc("R7");
    cmd = 3'd1; mode = 2'd3; strength = 3'd2; cyc("R7");
    do_reset();
    // R8 prefix
    cmd = 3'd1; keyed_en = 1; prefix = PFX ^ 48'h1; cyc("R8");
    chk("R8", "prefix code", int'(err_code), 3);
    do_reset();
    cmd = 3'd1; keyed_en = 1; cyc("R8");
    do_reset();
    // R10 priority
    cmd = 3'd1; mode = 2'd2; strength = 3'd4; keyed_en = 1; prefix = 48'h0;
    entropy_err = 1; allow_uns = 1; cyc("R10");
    chk("R10", "mode over prefix and entropy", int'(err_code), 2);
    cmd = 3'd4; entropy_err = 1; cyc("R10");
    cmd = 3'd1; keyed_en = 1; prefix = 48'h0; entropy_err = 1; cyc("R10");
    chk("R10", "prefix over entropy", int'(err_code), 3);
    // R12 escalation
    cmd = 3'd1; cyc("R12");
    cmd = 3'd5; entropy_err = 1; escalate = 1; cyc("R12");
    chk("R12", "terminal while blocked", int'(phase), 7);
    cmd = 3'd1; cyc("R12");
    cmd = 3'd6; cyc("R12");
    chk("R12", "no sequence error in terminal", int'(err_valid), 0);
    do_reset();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 5) cmd = 3'd0;
      else if (r < 9) begin
        case (m_ph)
          0: cmd = 3'd1;
          1: cmd = 3'd2;
          3: cmd = ($urandom % 2) ? 3'd3 : 3'd4;
          default: cmd = 3'($urandom % 8);
        endcase
      end else cmd = 3'($urandom % 8);
      app_active  = ($urandom % 5) == 0;
      absorbed    = ($urandom % 3 == 0) ? 4'b1010 : 4'($urandom);
      perm_done   = ($urandom % 3) == 0;
      entropy_err = ($urandom % 40) == 0;
      escalate    = ($urandom % 500) == 0;
      if ($urandom % 2) begin mode = 2'd0; strength = 3'd3; end
      else begin mode = 2'($urandom); strength = 3'($urandom); end
      keyed_en  = ($urandom % 3) == 0;
      prefix    = ($urandom % 2) ? PFX : {16'h0, 32'($urandom)};
      allow_uns = ($urandom % 2) == 1;
      cyc(tag_of(m_ph));
      if (m_ph == 7 && ($urandom % 4) == 0) do_reset();
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule